// File: doc/BRIEF.md
# Contactless Frame Receiver Checker

This block sits after the bit decoder of a contactless card front end. It takes a stream of logical bits, each marked by a valid strobe, and a strobe that marks the end of the frame. From these it rebuilds the received bytes, one strobe per byte. It runs every integrity check of the link on each frame at the same time: odd parity on each nine-bit group, the total bit count, the maximum frame length, and an optional trailing 16-bit CRC.

A frame starts with the first valid bit seen while idle. That bit is the start bit and carries no data. Each later group of nine bits is one data byte. The byte arrives least significant bit first and is followed by its parity bit. When the frame ends, the block raises a one-cycle done strobe. At the same time it presents four independent error flags and the final byte count. These results stay on the ports until the next frame's start bit arrives.

Top module: `frx_frame_checker`

## Requirements
- R1: The first valid bit taken while no frame is open is the start bit. It is never part of a byte. On the clock edge that takes it, `byte_count` and all four error flags return to 0.
- R2: Data bits fill each byte least significant bit first. One cycle after the edge that takes the ninth bit of a group, `byte_valid` is high for one cycle. `byte_data` then holds the eight data bits and `byte_count` has risen by one.
- R3: The ninth bit of each group is an odd parity bit. If the eight data bits and the parity bit together hold an even number of ones, `err_parity` is set for the frame. The byte is still delivered.
- R4: `err_bitcount` is set when the number of accepted bits after the start bit is not a whole multiple of nine. A trailing partial group produces no byte.
- R5: A frame may hold at most 163 bits, start bit included. Any later valid bit sets `err_overflow` and is otherwise ignored until the frame ends, so `byte_count` never goes above 18.
- R6: When `crc_en` is high at the end of a frame with two or more bytes, every byte is fed through a CRC_A register. The register uses preset 0x6363 and the reflected polynomial 0x8408, and the received CRC is appended low byte first. `err_crc` is set when the final register value is not zero.
- R7: While `crc_en` is low at the end of a frame, `err_crc` stays 0 whatever the bytes hold.
- R8: With `crc_en` high, a frame with exactly one byte sets `err_crc`.
- R9: A frame made of only the start bit raises `frame_done` with `byte_count` 0 and all error flags 0.
- R10: `frame_done` is high for one cycle, one cycle after the edge that takes `frame_end`. The flags and `byte_count` then hold until the next start bit.
- R11: `frame_end` with no frame open and no valid bit has no effect. `frame_end` together with a valid bit ends the frame after that bit has been counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | Check the trailing CRC on the frame that ends |
| bit_valid | input | 1 | A decoded bit is present on `bit_val` |
| bit_val | input | 1 | Decoded bit value |
| frame_end | input | 1 | End of the current frame |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte |
| byte_count | output | 5 | Bytes completed in the current or last frame |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| err_parity | output | 1 | At least one group failed odd parity |
| err_crc | output | 1 | CRC residue not zero, or a single byte under CRC |
| err_bitcount | output | 1 | Bits after the start bit not a multiple of nine |
| err_overflow | output | 1 | Frame ran past 163 bits |

## Verification
A group position that slips by one bit shows at the ports on the next `byte_valid`. The byte comes out shifted, and its parity check usually fails in the same frame. At `frame_done`, the bit-count flag turns wrong as well. A corrupted CRC register has no effect on the ports until `frame_done`, and then only when `crc_en` is high, so the bench compares every frame's CRC flag against a residue it computes itself. An error in the length counter shows only in frames near 163 bits: the nineteenth byte appears, or a byte is lost, and the overflow flag is wrong. For this reason the bench sends a frame that runs past the limit.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam logic [15:0] FRX_CRC_PRESET = 16'h6363;
    localparam logic [15:0] FRX_CRC_POLY   = 16'h8408;

    typedef struct packed {
        logic parity_err;
        logic crc_err;
        logic count_err;
        logic overflow_err;
    } frx_status_t;

    function automatic logic [15:0] frx_crc_step(input logic [15:0] cur,
                                                 input logic [7:0]  data);
        logic [15:0] r;
        r = cur ^ {8'h00, data};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ FRX_CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/frx_bit_assembler.sv
module frx_bit_assembler #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc,
    input  logic              bit_in,
    output logic              fire,
    output logic [DATA_W-1:0] fire_data,
    output logic              partial_next,
    output logic              par_next,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [CNT_W-1:0]  byte_count
);
    localparam int POS_W = $clog2(DATA_W + 1);
    localparam logic [POS_W-1:0] PAR_SLOT = POS_W'(DATA_W);

    logic [POS_W-1:0]  pos_q, pos_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_q;

    always_comb begin
        pos_n    = pos_q;
        sh_n     = sh_q;
        cnt_next = cnt_q;
        par_next = par_q;
        fire     = 1'b0;
        if (clr) begin
            pos_n    = '0;
            cnt_next = '0;
            par_next = 1'b0;
        end else if (acc) begin
            if (pos_q == PAR_SLOT) begin
                fire     = 1'b1;
                pos_n    = '0;
                cnt_next = cnt_q + 1'b1;
                if (!(^{sh_q, bit_in})) par_next = 1'b1;
            end else begin
                sh_n  = {bit_in, sh_q[DATA_W-1:1]};
                pos_n = pos_q + 1'b1;
            end
        end
    end

    assign fire_data    = sh_q;
    assign partial_next = (pos_n != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= '0;
            sh_q       <= '0;
            cnt_q      <= '0;
            par_q      <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            pos_q      <= pos_n;
            sh_q       <= sh_n;
            cnt_q      <= cnt_next;
            par_q      <= par_next;
            byte_valid <= fire;
            if (fire) byte_data <= sh_q;
        end
    end

    assign byte_count = cnt_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> (byte_count == $past(byte_count) + 1'b1));

    assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
        pos_q <= PAR_SLOT);

endmodule

// File: rtl/frx_crc_unit.sv
module frx_crc_unit
    import frx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fire,
    input  logic [DATA_W-1:0] data,
    output logic [15:0]       crc_next
);
    logic [15:0] crc_q;

    always_comb begin
        crc_next = crc_q;
        if (clr)       crc_next = FRX_CRC_PRESET;
        else if (fire) crc_next = frx_crc_step(crc_q, data[7:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= FRX_CRC_PRESET;
        else     crc_q <= crc_next;
    end

    assert_preset_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (crc_q == FRX_CRC_PRESET));

endmodule

// File: rtl/frx_frame_ctrl.sv
module frx_frame_ctrl
    import frx_pkg::*;
#(
    parameter int MAX_BITS = 163,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             crc_en,
    input  logic             bit_valid,
    input  logic             frame_end,
    input  logic             partial_next,
    input  logic             par_next,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [15:0]      crc_next,
    output logic             frame_start,
    output logic             acc,
    output logic             done,
    output frx_status_t      status
);
    localparam int BCNT_W = $clog2(MAX_BITS + 1);
    localparam logic [BCNT_W-1:0] CAP = BCNT_W'(MAX_BITS);

    logic              in_frame_q;
    logic [BCNT_W-1:0] bits_q;
    logic              ov_q, ov_next;
    logic              at_cap, closing;
    frx_status_t       result;

    assign frame_start = bit_valid && !in_frame_q;
    assign at_cap      = (bits_q == CAP);
    assign acc         = bit_valid && in_frame_q && !at_cap;
    assign ov_next     = frame_start ? 1'b0
                                     : (ov_q || (bit_valid && in_frame_q && at_cap));
    assign closing     = frame_end && (in_frame_q || bit_valid);

    always_comb begin
        result.parity_err   = par_next;
        result.count_err    = partial_next;
        result.overflow_err = ov_next;
        result.crc_err      = crc_en && ((cnt_next == CNT_W'(1)) ||
                              ((cnt_next > CNT_W'(1)) && (crc_next != 16'h0000)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            bits_q     <= '0;
            ov_q       <= 1'b0;
            done       <= 1'b0;
            status     <= '0;
        end else begin
            ov_q <= ov_next;
            done <= closing;
            if (frame_start)  bits_q <= BCNT_W'(1);
            else if (acc)     bits_q <= bits_q + 1'b1;
            if (closing)          in_frame_q <= 1'b0;
            else if (frame_start) in_frame_q <= 1'b1;
            if (closing)          status <= result;
            else if (frame_start) status <= '0;
        end
    end

    assert_overflow_at_cap_R5: assert property (@(posedge clk) disable iff (rst)
        ov_q |-> (bits_q == CAP));

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(closing) && !$past(frame_start)) |-> $stable(status));

    assert_crc_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (done && status.crc_err) |-> $past(crc_en));

endmodule

// File: rtl/frx_frame_checker.sv
module frx_frame_checker
    import frx_pkg::*;
#(
    parameter int MAX_BITS = 163,
    parameter int DATA_W   = 8,
    localparam int CNT_W   = $clog2((MAX_BITS - 1) / (DATA_W + 1) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crc_en,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              frame_end,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [CNT_W-1:0]  byte_count,
    output logic              frame_done,
    output logic              err_parity,
    output logic              err_crc,
    output logic              err_bitcount,
    output logic              err_overflow
);
    logic              frame_start, acc, fire, partial_next, par_next;
    logic [DATA_W-1:0] fire_data;
    logic [CNT_W-1:0]  cnt_next;
    logic [15:0]       crc_next;
    frx_status_t       status;

    frx_frame_ctrl #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .crc_en(crc_en), .bit_valid(bit_valid),
        .frame_end(frame_end), .partial_next(partial_next), .par_next(par_next),
        .cnt_next(cnt_next), .crc_next(crc_next), .frame_start(frame_start),
        .acc(acc), .done(frame_done), .status(status)
    );

    frx_bit_assembler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
        .clk(clk), .rst(rst), .clr(frame_start), .acc(acc), .bit_in(bit_val),
        .fire(fire), .fire_data(fire_data), .partial_next(partial_next),
        .par_next(par_next), .cnt_next(cnt_next), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_count(byte_count)
    );

    frx_crc_unit #(.DATA_W(DATA_W)) u_crc (
        .clk(clk), .rst(rst), .clr(frame_start), .fire(fire),
        .data(fire_data), .crc_next(crc_next)
    );

    assign err_parity   = status.parity_err;
    assign err_crc      = status.crc_err;
    assign err_bitcount = status.count_err;
    assign err_overflow = status.overflow_err;

endmodule

// File: tb/sim_frx_frame_checker.sv
`timescale 1ns/1ps
module sim_frx_frame_checker;

    logic clk = 1'b0, rst = 1'b1;
    logic crc_en = 1'b0, bit_valid = 1'b0, bit_val = 1'b0, frame_end = 1'b0;
    logic       byte_valid, frame_done;
    logic [7:0] byte_data;
    logic [4:0] byte_count;
    logic       err_parity, err_crc, err_bitcount, err_overflow;

    always #10 clk = ~clk;

    frx_frame_checker u0 (
        .clk(clk), .rst(rst), .crc_en(crc_en), .bit_valid(bit_valid),
        .bit_val(bit_val), .frame_end(frame_end), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_count(byte_count), .frame_done(frame_done),
        .err_parity(err_parity), .err_crc(err_crc), .err_bitcount(err_bitcount),
        .err_overflow(err_overflow)
    );

    typedef struct {
        int cnt;
        bit par;
        bit crc;
        bit bc;
        bit ov;
    } exp_t;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic       bq[$];
    logic [7:0] fb[$];
    bit         fbad[$];
    logic [7:0] byte_q[$];
    exp_t       stat_q[$];
    string      tag_q[$];
    exp_t       last_exp;

    task automatic check(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic new_frame();
        bq.delete(); fb.delete(); fbad.delete();
        bq.push_back(1'b0);
    endtask

    task automatic add_byte(input logic [7:0] b, input bit bad);
        for (int i = 0; i < 8; i++) bq.push_back(b[i]);
        bq.push_back((~^b) ^ bad);
        fb.push_back(b);
        fbad.push_back(bad);
    endtask

    task automatic add_crc(input bit corrupt);
        logic [15:0] c = 16'h6363;
        foreach (fb[i]) c = crc_ref(c, fb[i]);
        if (corrupt) c = c ^ 16'h0001;
        add_byte(c[7:0], 1'b0);
        add_byte(c[15:8], 1'b0);
    endtask

    task automatic check_cleared(input string tag);
        check(byte_count, 0, {tag, " R1 count cleared at start"});
        check({err_parity, err_crc, err_bitcount, err_overflow}, 0,
              {tag, " R10 flags cleared at start"});
    endtask

    task automatic play(input bit ce, input bit end_together, input int gap, input string tag);
        exp_t e;
        int total, accepted, data, nb;
        logic [15:0] c;
        total    = bq.size();
        accepted = (total > 163) ? 163 : total;
        data     = accepted - 1;
        nb       = data / 9;
        e.cnt = nb; e.par = 0; e.bc = (data % 9) != 0; e.ov = total > 163;
        c = 16'h6363;
        for (int i = 0; i < nb; i++) begin
            byte_q.push_back(fb[i]);
            if (fbad[i]) e.par = 1;
            c = crc_ref(c, fb[i]);
        end
        e.crc = ce && ((nb == 1) || (nb >= 2 && c != 16'h0000));
        // R10: previous results still held before this frame begins
        @(negedge clk);
        check({err_parity, err_crc, err_bitcount, err_overflow},
              {last_exp.par, last_exp.crc, last_exp.bc, last_exp.ov}, {tag, " R10 flags held"});
        check(byte_count, last_exp.cnt, {tag, " R10 count held"});
        stat_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        crc_en = ce;
        for (int i = 0; i < total; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1 && gap == 0) check_cleared(tag);
            bit_valid = 1'b1;
            bit_val   = bq[i];
            frame_end = end_together && (i == total - 1);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (i == 0 && g == 0) check_cleared(tag);
                bit_valid = 1'b0;
                frame_end = 1'b0;
            end
        end
        @(negedge clk);
        bit_valid = 1'b0;
        frame_end = !end_together;
        @(negedge clk);
        frame_end = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares bytes and end-of-frame status against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (byte_q.size() == 0) check(1, 0, "R2 unexpected byte");
                else check(byte_data, byte_q.pop_front(), "R2 byte value");
            end
            if (frame_done) begin
                if (stat_q.size() == 0) check(1, 0, "R11 unexpected frame_done");
                else begin
                    exp_t e;
                    string t;
                    e = stat_q.pop_front();
                    t = tag_q.pop_front();
                    check(byte_count,   e.cnt, {t, " count R2/R9"});
                    check(err_parity,   e.par, {t, " parity R3"});
                    check(err_bitcount, e.bc,  {t, " bitcount R4"});
                    check(err_overflow, e.ov,  {t, " overflow R5"});
                    check(err_crc,      e.crc, {t, " crc R6/R7/R8"});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        last_exp = '{cnt: 0, par: 0, crc: 0, bc: 0, ov: 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({byte_valid, frame_done, err_parity, err_crc, err_bitcount, err_overflow}, 0,
              "R10 reset state flags");
        check(byte_count, 0, "R1 reset byte count");

        // R6: correct trailing CRC
        new_frame(); add_byte(8'h30, 0); add_byte(8'h04, 0); add_crc(0);
        play(1, 0, 0, "R6 good crc");
        // R6: corrupted CRC
        new_frame(); add_byte(8'h30, 0); add_byte(8'h04, 0); add_crc(1);
        play(1, 0, 0, "R6 bad crc");
        // R7: same corruption, checking disabled
        new_frame(); add_byte(8'h30, 0); add_byte(8'h04, 0); add_crc(1);
        play(0, 0, 1, "R7 crc off");
        // R8: single byte under CRC
        new_frame(); add_byte(8'hA5, 0);
        play(1, 0, 0, "R8 one byte");
        // R9: start bit only, ended with the bit and separately
        new_frame();
        play(1, 1, 0, "R9 empty joint end");
        new_frame();
        play(1, 0, 0, "R9 empty");
        // R3: bad parity on first byte, byte still delivered
        new_frame(); add_byte(8'h11, 1); add_byte(8'hFE, 0);
        play(0, 0, 2, "R3 parity");
        // R4: trailing partial group
        new_frame(); add_byte(8'h5A, 0); add_byte(8'hC3, 0);
        for (int i = 0; i < 4; i++) bq.push_back(i[0]);
        play(0, 0, 0, "R4 partial");
        // R5: longer than the limit, ends together with an ignored bit
        new_frame();
        for (int i = 0; i < 20; i++) add_byte(8'(i * 7 + 1), 0);
        play(0, 1, 0, "R5 overflow");
        // R11: frame_end together with the last parity bit
        new_frame(); add_byte(8'h93, 0); add_byte(8'h20, 0); add_byte(8'h7E, 0); add_crc(0);
        play(1, 1, 0, "R11 joint end");

        // R11: stray frame_end while idle has no effect
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
        @(negedge clk);
        check(frame_done, 0, "R11 stray end no done");
        check({err_parity, err_crc, err_bitcount, err_overflow},
              {last_exp.par, last_exp.crc, last_exp.bc, last_exp.ov}, "R11 stray end flags");
        check(byte_count, last_exp.cnt, "R11 stray end count");

        repeat (5) @(negedge clk);
        check(byte_q.size(), 0, "R2 all bytes seen");
        check(stat_q.size(), 0, "R10 all frames done");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule